// File: doc/BRIEF.md
# B3ZS/HDB3 Line Decoder with Violation Flag

This block sits behind the clock and data recovery of a high-speed coaxial line receiver. Each clock it takes one recovered bipolar symbol, given as a positive-rail and a negative-rail bit. In NRZ mode it rebuilds the NRZ bit stream by removing the zero-substitution patterns inserted by the far-end encoder. A select input chooses the three-zero code (B3ZS) or the four-zero code (HDB3). Beside the data it drives a one-symbol-wide line-code-violation flag. The flag marks bipolar violations that are not part of a legal substitution, substitutions with the wrong mark parity, over-long zero runs and symbols with both rails set.

With NRZ mode off the block applies no decoding. It carries both rails to its outputs through the same pipeline, so timing does not change between modes. Only a violation that completes a legal substitution is removed, together with its balancing mark. Any other violation stays in the data as a one and is flagged.

Top module: `lcv_decoder`

## Requirements
- R1: With nrz_en_i=0, data_o repeats pos_i and flag_o repeats neg_i, symbol for symbol, with the latency of R2 and no decoding applied.
- R2: A symbol sampled at rising edge n is shown on data_o and flag_o from just after edge n+3 until edge n+4, in both modes, and the data and flag of a symbol always appear together.
- R3: Symbol encoding: pos_i=1,neg_i=0 is a positive mark; pos_i=0,neg_i=1 is a negative mark; both 0 is a zero. In NRZ mode a mark whose polarity differs from the previous mark, or the first mark after reset, gives data 1 and flag 0. A zero that does not complete an over-long run gives data 0 and flag 0.
- R4: With b3zs_i=1, a violation (a mark with the same polarity as the previous mark) is a legal substitution in two cases: it directly follows one zero, and an odd number of non-violating marks has arrived since the previous violation or reset. In that case the violation gives data 0 with no flag. If the symbol two places before it is a mark, that mark also gives data 0.
- R5: With b3zs_i=0, a violation is a legal substitution in two cases: it directly follows two zeros, and the mark count of R4 is odd. In that case it gives data 0 with no flag. If the symbol three places before it is a mark, that mark also gives data 0.
- R6: A violation directly after a mark is flagged (flag 1, data 1). Under b3zs_i=0 a violation after the pattern mark,zero is also flagged. A violation whose required zeros include a dual-rail symbol is also flagged.
- R7: A violation preceded by the required zeros (one for b3zs_i=1, two for b3zs_i=0) is a coding error when the mark count of R4 is even. It gives flag 1 and data 1. Every violation, legal or not, resets that count to even.
- R8: In NRZ mode the third consecutive zero (b3zs_i=1) or the fourth (b3zs_i=0) gives flag 1 and data 0. Further zeros of the same run are not flagged.
- R9: A symbol with both rails set gives flag 1 and data 0 in NRZ mode. It ends any zero run and changes neither the last-mark polarity nor the mark count.
- R10: rst_ni low clears data_o and flag_o at once and clears all history. After release the first mark is never a violation, the zero run is empty and the mark count is even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nrz_en_i | input | 1 | 1: decode to NRZ with violation flag; 0: carry rails unchanged |
| b3zs_i | input | 1 | 1: three-zero substitution code; 0: four-zero code |
| pos_i | input | 1 | Positive-rail symbol bit |
| neg_i | input | 1 | Negative-rail symbol bit |
| data_o | output | 1 | NRZ data (NRZ mode) or delayed positive rail |
| flag_o | output | 1 | Violation flag (NRZ mode) or delayed negative rail |

## Verification
Two actions can fall in the same clock. A legal substitution reaches back into the pipeline and clears its balancing mark. In that cycle the output stage may be showing an older symbol that carries its own flag, often the last zero of an over-long run. The bench provokes this with zero bursts and random rail errors injected into streams that a bench encoder codes legally, and with directed strings that place a run straight before a substitution. Every output symbol is compared against a bench model that reads the whole stream at once, so a clear that hits the wrong stage or a lost flag shows up at its own index.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  typedef struct packed {
    logic mrk;  // exactly one rail set
    logic pol;  // 1: positive
    logic zro;  // neither rail set
  } sym_t;

  function automatic sym_t sym_of(input logic p, input logic n);
    sym_t s;
    s.mrk = p ^ n;
    s.pol = p;
    s.zro = ~(p | n);
    return s;
  endfunction
endpackage

// File: rtl/lcv_hist.sv
module lcv_hist
  import lcv_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  sym_t                  sym_i,
  output sym_t [DEPTH-1:0]      hist_o
);
  sym_t [DEPTH-1:0] hist_q;

  // index 0 is the symbol one period back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[DEPTH-2:0], sym_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/lcv_rules.sv
module lcv_rules
  import lcv_pkg::*;
#(
  parameter int unsigned RUN_B3 = 3,
  parameter int unsigned RUN_HD = 4,
  parameter int unsigned HW     = RUN_HD - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              b3zs_i,
  input  sym_t              sym_i,
  input  sym_t [HW-1:0]     hist_i,
  output logic              bit_o,
  output logic              flag_o,
  output logic [HW-1:0]     kill_o
);
  localparam int unsigned ZW = $clog2(RUN_HD + 1);

  logic [ZW-1:0] lim, zrun_q;
  logic          pol_q, seen_q, par_q;
  logic          is_v, pre_ok, bmark, strip;
  logic [HW-1:0] bsel;
  logic          unused_hist_pol;

  always_comb begin
    lim    = b3zs_i ? ZW'(RUN_B3) : ZW'(RUN_HD);
    pre_ok = 1'b1;
    bmark  = 1'b0;
    bsel   = '0;
    unused_hist_pol = 1'b0;
    for (int k = 0; k < int'(HW); k++) begin
      if (k < int'(lim) - 2) pre_ok = pre_ok & hist_i[k].zro;
      if (k == int'(lim) - 2) begin
        bmark   = hist_i[k].mrk;
        bsel[k] = 1'b1;
      end
      unused_hist_pol = unused_hist_pol ^ hist_i[k].pol;
    end

    is_v   = sym_i.mrk & seen_q & (sym_i.pol == pol_q);
    bit_o  = 1'b0;
    flag_o = 1'b0;
    strip  = 1'b0;
    if (sym_i.zro)                 flag_o = (zrun_q == lim - ZW'(1));
    else if (!sym_i.mrk)           flag_o = 1'b1;            // both rails
    else if (is_v && pre_ok && par_q) strip = 1'b1;          // legal substitution
    else begin
      bit_o  = 1'b1;
      flag_o = is_v;
    end
    kill_o = (strip && bmark) ? bsel : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zrun_q <= '0;
      pol_q  <= 1'b0;
      seen_q <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      if (sym_i.zro) begin
        if (zrun_q < lim) zrun_q <= zrun_q + ZW'(1);
      end else begin
        zrun_q <= '0;
      end
      if (is_v) begin
        par_q <= 1'b0;
      end else if (sym_i.mrk) begin
        par_q  <= ~par_q;
        pol_q  <= sym_i.pol;
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcv_align.sv
module lcv_align #(
  parameter int unsigned LAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             flag_i,
  input  logic [LAT-2:0]   kill_i,
  output logic             data_o,
  output logic             flag_o
);
  logic [LAT-1:0] d_q, f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      f_q <= '0;
    end else begin
      d_q <= {d_q[LAT-2:0] & ~kill_i, bit_i};
      f_q <= {f_q[LAT-2:0], flag_i};
    end
  end

  assign data_o = d_q[LAT-1];
  assign flag_o = f_q[LAT-1];
endmodule

// File: rtl/lcv_decoder.sv
module lcv_decoder
  import lcv_pkg::*;
#(
  parameter int unsigned RUN_B3 = 3,
  parameter int unsigned RUN_HD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nrz_en_i,
  input  logic b3zs_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic data_o,
  output logic flag_o
);
  localparam int unsigned HW  = RUN_HD - 1;
  localparam int unsigned LAT = RUN_HD;

  sym_t          sym;
  sym_t [HW-1:0] hist;
  logic          dec_bit, dec_flag;
  logic [HW-1:0] dec_kill;
  logic          pipe_bit, pipe_flag;
  logic [HW-1:0] pipe_kill;

  assign sym = sym_of(pos_i, neg_i);

  lcv_hist #(.DEPTH(HW)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sym_i  (sym),
    .hist_o (hist)
  );

  lcv_rules #(.RUN_B3(RUN_B3), .RUN_HD(RUN_HD), .HW(HW)) u_rules (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .b3zs_i (b3zs_i),
    .sym_i  (sym),
    .hist_i (hist),
    .bit_o  (dec_bit),
    .flag_o (dec_flag),
    .kill_o (dec_kill)
  );

  assign pipe_bit  = nrz_en_i ? dec_bit  : pos_i;
  assign pipe_flag = nrz_en_i ? dec_flag : neg_i;
  assign pipe_kill = nrz_en_i ? dec_kill : '0;

  lcv_align #(.LAT(LAT)) u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (pipe_bit),
    .flag_i (pipe_flag),
    .kill_i (pipe_kill),
    .data_o (data_o),
    .flag_o (flag_o)
  );
endmodule

// File: rtl/lcv_decoder_chk.sv
module lcv_decoder_chk #(
  parameter int unsigned LAT = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic nrz_en_i,
  input logic pos_i,
  input logic neg_i,
  input logic data_o,
  input logic flag_o
);
  localparam int unsigned AW = $clog2(LAT + 2) + 1;

  logic [AW-1:0] age_q;
  logic          nrz_prev_q;
  logic          settled;

  // edges since reset during which the mode stayed put
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q      <= '0;
      nrz_prev_q <= 1'b0;
    end else begin
      nrz_prev_q <= nrz_en_i;
      if (nrz_en_i != nrz_prev_q)      age_q <= '0;
      else if (age_q < AW'(LAT + 1))   age_q <= age_q + AW'(1);
    end
  end

  assign settled = (age_q >= AW'(LAT + 1));

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r10: assert (!data_o && !flag_o);
  end

  p_pass_rails_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && !nrz_en_i) |-> (data_o == $past(pos_i, LAT)) && (flag_o == $past(neg_i, LAT)));

  p_ones_from_marks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && nrz_en_i && data_o) |-> $past(pos_i ^ neg_i, LAT));

  p_dual_rail_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && nrz_en_i && $past(pos_i && neg_i, LAT)) |-> (flag_o && !data_o));
endmodule

bind lcv_decoder lcv_decoder_chk #(.LAT(RUN_HD)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .nrz_en_i (nrz_en_i),
  .pos_i    (pos_i),
  .neg_i    (neg_i),
  .data_o   (data_o),
  .flag_o   (flag_o)
);

// File: tb/lcv_decoder_tb_top.sv
module lcv_decoder_tb_top;
  localparam int MAXS = 2048;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, nrz_en_i = 1'b0, b3zs_i = 1'b0, pos_i = 1'b0, neg_i = 1'b0;
  logic data_o, flag_o;

  always #5 clk = ~clk;

  lcv_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .nrz_en_i(nrz_en_i), .b3zs_i(b3zs_i),
    .pos_i(pos_i), .neg_i(neg_i), .data_o(data_o), .flag_o(flag_o)
  );

  bit    sp[MAXS], sn[MAXS], ob[MAXS], ed[MAXS], ef[MAXS];
  string tg[MAXS];
  int    total = 0, bad = 0;
  bit    done = 1'b0;

  task automatic chk(string req, int idx, logic a_d, logic a_f, logic e_d, logic e_f);
    total++;
    if (a_d !== e_d || a_f !== e_f) begin
      bad++;
      $display("FAIL %s sym=%0d actual data=%b flag=%b expected data=%b flag=%b",
               req, idx, a_d, a_f, e_d, e_f);
    end
  endtask

  function automatic bit isz(int k);
    return (k >= 0) && !sp[k] && !sn[k];
  endfunction

  function automatic bit ism(int k);
    return (k >= 0) && (sp[k] ^ sn[k]);
  endfunction

  function automatic void put(int i, bit pol);
    sp[i] = pol;
    sn[i] = !pol;
  endfunction

  // expected outputs straight from the requirements, whole stream at once
  function automatic void model(bit nrz, bit b3, int len);
    bit lp = 0, hv = 0, par = 0;
    int zr = 0;
    int lim = b3 ? 3 : 4;
    for (int i = 0; i < len; i++) begin
      ed[i] = 0; ef[i] = 0; tg[i] = "R3";
      if (!nrz) begin
        ed[i] = sp[i]; ef[i] = sn[i]; tg[i] = "R1";
      end else if (sp[i] && sn[i]) begin
        ef[i] = 1; tg[i] = "R9"; zr = 0;
      end else if (!sp[i] && !sn[i]) begin
        zr++;
        if (zr == lim) begin ef[i] = 1; tg[i] = "R8"; end
      end else begin
        zr = 0;
        if (hv && sp[i] == lp) begin
          bit pre;
          pre = b3 ? isz(i-1) : (isz(i-1) && isz(i-2));
          if (pre && par) begin
            tg[i] = b3 ? "R4" : "R5";
            if (ism(i-lim+1)) begin ed[i-lim+1] = 0; tg[i-lim+1] = tg[i]; end
          end else begin
            ed[i] = 1; ef[i] = 1; tg[i] = pre ? "R7" : "R6";
          end
          par = 0;
        end else begin
          ed[i] = 1; par = ~par; lp = sp[i]; hv = 1;
        end
      end
    end
  endfunction

  // legal line coding of ob[], then optional damage
  function automatic void enc(bit b3, int len, int errpct);
    bit lp = 1, par = 0;
    int zc = 0;
    int lim = b3 ? 3 : 4;
    for (int i = 0; i < len; i++) begin
      if (ob[i]) begin
        put(i, !lp); lp = !lp; par = ~par; zc = 0;
      end else begin
        sp[i] = 0; sn[i] = 0; zc++;
        if (zc == lim) begin
          if (par) put(i, lp);
          else begin put(i-lim+1, !lp); put(i, !lp); lp = !lp; end
          par = 0; zc = 0;
        end
      end
    end
    for (int i = 0; i < len; i++) begin
      if (int'($urandom_range(99)) < errpct) begin
        sp[i] = 1'($urandom_range(1)); sn[i] = 1'($urandom_range(1));
      end
      if (errpct > 0 && $urandom_range(99) == 0 && i + 6 < len)
        for (int k = 0; k < 6; k++) begin sp[i+k] = 0; sn[i+k] = 0; end
    end
  endfunction

  function automatic int load(string s);
    for (int i = 0; i < s.len(); i++) begin
      sp[i] = (s[i] == "+") || (s[i] == "x");
      sn[i] = (s[i] == "-") || (s[i] == "x");
    end
    return s.len();
  endfunction

  task automatic run_seg(bit nrz, bit b3, int len);
    model(nrz, b3, len);
    @(negedge clk);
    rst_ni = 0; pos_i = 0; neg_i = 0; nrz_en_i = nrz; b3zs_i = b3;
    @(negedge clk);
    chk("R10 reset", -1, data_o, flag_o, 0, 0);
    rst_ni = 1; pos_i = sp[0]; neg_i = sn[0];
    for (int t = 1; t < len + 4; t++) begin
      @(negedge clk);
      if (t >= 4) chk(tg[t-4], t-4, data_o, flag_o, ed[t-4], ef[t-4]);
      pos_i = (t < len) ? sp[t] : 1'b0;
      neg_i = (t < len) ? sn[t] : 1'b0;
    end
  endtask

  task automatic lat_chk();
    @(negedge clk);
    rst_ni = 0; nrz_en_i = 1; b3zs_i = 1; pos_i = 0; neg_i = 0;
    @(negedge clk);
    rst_ni = 1; pos_i = 1;
    for (int t = 1; t <= 4; t++) begin
      @(negedge clk);
      pos_i = 0;
      chk("R2 latency", t, data_o, flag_o, (t == 4), 0);
    end
  endtask

  task automatic async_rst_chk();
    @(negedge clk);
    rst_ni = 0; nrz_en_i = 0; pos_i = 0; neg_i = 0;
    @(negedge clk);
    rst_ni = 1; pos_i = 1; neg_i = 1;
    repeat (6) @(negedge clk);
    chk("R1 rails high", 0, data_o, flag_o, 1, 1);
    rst_ni = 0;
    #1;
    chk("R10 async clear", 0, data_o, flag_o, 0, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'h1dc0_5eed));
    lat_chk();
    async_rst_chk();
    // transparent, random rails
    for (int i = 0; i < 1200; i++) begin
      sp[i] = 1'($urandom_range(1)); sn[i] = 1'($urandom_range(1));
    end
    run_seg(0, 1, 1200);
    // clean and damaged coded streams, both codes
    for (int seg = 0; seg < 4; seg++) begin
      ob[0] = 1;
      for (int i = 1; i < 1500; i++) ob[i] = ($urandom_range(2) != 0) ? 1'b0 : 1'b1;
      enc(seg[0], 1500, (seg >= 2) ? 4 : 0);
      run_seg(1, seg[0], 1500);
    end
    // directed corners
    n = load("+-+0+-00--+0+00+x+000000-+-0-0+00-+x00+-0++");
    run_seg(1, 1, n);
    n = load("+-+00+-000-+0+--+00+x-00000+-0+00-+000+-00-x0000+-00++");
    run_seg(1, 0, n);
    n = load("+-000+0000-+--0+");
    run_seg(1, 1, n);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule